// File: doc/BRIEF.md
# Descriptor-Ring Frame Queue Manager

This block holds a table of buffer descriptors that software fills and inspects through a simple word-wide register port. A programmable boundary splits the table into two rings: the leading entries are transmit descriptors, the rest are receive descriptors. Each descriptor is a pair of 32-bit words, a status/length word and a buffer-address word. The block walks each ring by itself. Hardware owns a descriptor while its ownership bit is set, and the engine writes completion status back into that descriptor's own status word.

On the transmit side, a descriptor marked ready becomes one frame request. The request carries the buffer address, length, padding flag and checksum flag, and it is held until the frame mover answers with done and a status code. That status is then written back, ownership returns to software, and the pointer moves on. On the receive side, each frame report strobe claims the current empty descriptor and writes the received length and error flags into it. If that descriptor is still owned by software, the report is counted as a drop.

Descriptor events set bits in an interrupt source register. Software clears a bit by writing 1 to it. A mask register selects which source bits drive the interrupt output. Moving frame data, checksums and the line interface are handled elsewhere.

Top module: `dring_qmgr`

## Requirements
- R1: After reset the interrupt source register reads 0, the interrupt output and the transmit request are low, every descriptor status word reads 0, and the transmit count reads its default of 64.
- R2: Registers are word addressed: control at 0x00 (bit 0 receive enable, bit 1 transmit enable), interrupt source at 0x04, interrupt mask at 0x08 (bits 6:0), transmit count at 0x20. Descriptor i occupies 0x400+8*i (status word) and 0x404+8*i (address word). A transmit count written above the table size (128) reads back as 128.
- R3: When transmit is enabled, the current transmit descriptor has bit 15 (ready) set and its index is below the transmit count, tx_req rises. tx_req then carries the address word, status bits 31:16 as the length, bit 12 as pad and bit 11 as checksum enable, and it stays high until tx_done. Each ready descriptor produces exactly one request.
- R4: On tx_done, the descriptor's status bits 8:0 take tx_stat and bit 15 is cleared. Bits 31:16 and 14:9 are kept, and tx_req falls in the next cycle.
- R5: After a descriptor with bit 13 (wrap) is handled, the pointer returns to the first entry of its ring: entry 0 for transmit, entry <transmit count> for receive. The pointer also returns there after the last entry of the ring.
- R6: A rx_frame strobe while receive is enabled and the current receive descriptor has bit 15 (empty) set writes rx_len into bits 31:16 and rx_flags into bits 8:0, clears bit 15, keeps bits 14:9, and advances the receive pointer.
- R7: A rx_frame strobe while receive is enabled and no empty descriptor is current sets source bit 4 (drop). No descriptor is written and the pointer stays.
- R8: A completed descriptor sets a source bit only if its bit 14 is 1. For transmit, bit 1 is set if any of tx_stat bits 0, 2, 3 or 8 is 1, otherwise bit 0. For receive, bit 3 is set if any of rx_flags bits 7:0 is 1, otherwise bit 6 if rx_flags bit 8 is 1, otherwise bit 2.
- R9: Writing 1 to a source bit clears it. A bit set by an event in the same cycle as a clear of that bit stays set.
- R10: irq is high exactly when the source register ANDed with the mask register is non-zero.
- R11: With transmit enable clear, no request is issued and no transmit descriptor changes. With receive enable clear, rx_frame is ignored: no write-back and no drop bit.
- R12: Writing the transmit count moves the transmit pointer to entry 0 and the receive pointer to the entry equal to the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_req | output | 1 | Frame request, held until tx_done |
| tx_addr | output | 32 | Buffer address of the requested frame |
| tx_len | output | 16 | Length of the requested frame |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append checksum |
| tx_done | input | 1 | Frame request finished |
| tx_stat | input | 9 | Completion status written back |
| rx_frame | input | 1 | Received frame report strobe |
| rx_len | input | 16 | Received frame length |
| rx_flags | input | 9 | Received frame error and control flags |
| irq | output | 1 | Masked interrupt |

## Verification
Within a single cycle, a software write-one-to-clear to the interrupt source register can coincide with a descriptor completion that sets the same bit. The bench provokes this by driving rx_frame and a clearing write to bit 2 on the same clock edge. It then expects bit 2 to still read 1 afterwards, and expects a later clear with no competing event to take effect. A transmit write-back and a receive write-back can also land in the same cycle on different table entries. For that reason each engine has its own table write port, and both descriptors are read back.

// File: rtl/dring_pkg.sv
package dring_pkg;
    // status word bit positions (transmit)
    localparam int TXB_READY = 15;
    localparam int TXB_IRQ   = 14;
    localparam int TXB_WRAP  = 13;
    localparam int TXB_PAD   = 12;
    localparam int TXB_CRC   = 11;
    // status word bit positions (receive)
    localparam int RXB_EMPTY = 15;
    localparam int RXB_IRQ   = 14;
    localparam int RXB_WRAP  = 13;
    // interrupt source bits
    localparam int IB_TXF  = 0;
    localparam int IB_TXE  = 1;
    localparam int IB_RXF  = 2;
    localparam int IB_RXE  = 3;
    localparam int IB_DROP = 4;
    localparam int IB_RXC  = 6;
    localparam int NSRC    = 7;
    // register offsets
    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_SRC   = 'h004;
    localparam int OFS_MASK  = 'h008;
    localparam int OFS_TXCNT = 'h020;
    localparam int OFS_TABLE = 'h400;

    typedef enum logic {TX_IDLE, TX_BUSY} tx_state_e;
endpackage

// File: rtl/dring_table.sv
module dring_table #(
    parameter int N  = 128,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [IW-1:0] bus_idx,
    input  logic          bus_hi,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [IW-1:0] tx_idx,
    input  logic          tx_we,
    input  logic [31:0]   tx_wdata,
    output logic [31:9]   tx_stat,
    output logic [31:0]   tx_addr,
    input  logic [IW-1:0] rx_idx,
    input  logic          rx_we,
    input  logic [31:0]   rx_wdata,
    output logic [15:9]   rx_stat
);
    logic [31:0] stat_d [N];
    logic [31:0] stat_q [N];
    logic [31:0] addr_d [N];
    logic [31:0] addr_q [N];

    always_comb begin
        stat_d = stat_q;
        addr_d = addr_q;
        if (bus_we) begin
            if (bus_hi) addr_d[bus_idx] = bus_wdata;
            else        stat_d[bus_idx] = bus_wdata;
        end
        // engine write-backs override a software write to the same word
        if (tx_we) stat_d[tx_idx] = tx_wdata;
        if (rx_we) stat_d[rx_idx] = rx_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                stat_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            stat_q <= stat_d;
            addr_q <= addr_d;
        end
    end

    assign bus_rdata = bus_hi ? addr_q[bus_idx] : stat_q[bus_idx];
    assign tx_stat   = stat_q[tx_idx][31:9];
    assign tx_addr   = addr_q[tx_idx];
    assign rx_stat   = stat_q[rx_idx][15:9];
endmodule

// File: rtl/dring_tx.sv
module dring_tx
    import dring_pkg::*;
#(
    parameter int IW = 7,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] count,
    input  logic          restart,
    input  logic [31:9]   stat_in,
    input  logic [31:0]   addr_in,
    input  logic          done,
    input  logic [8:0]    done_stat,
    output logic [IW-1:0] ptr,
    output logic          req,
    output logic [31:0]   req_addr,
    output logic [15:0]   req_len,
    output logic          req_pad,
    output logic          req_crc,
    output logic          wb_we,
    output logic [31:0]   wb_data,
    output logic          set_txf,
    output logic          set_txe
);
    typedef struct packed {
        tx_state_e     st;
        logic [IW-1:0] ptr;
        logic          rst_pend;
        logic [31:0]   addr;
        logic [15:0]   len;
        logic          pad;
        logic          crc;
    } tx_reg_t;

    tx_reg_t q, d;
    logic [CW-1:0] ptr_inc;
    logic          last, err;

    always_comb begin
        d       = q;
        wb_we   = 1'b0;
        set_txf = 1'b0;
        set_txe = 1'b0;
        wb_data = {stat_in[31:16], 1'b0, stat_in[14:9], done_stat};
        ptr_inc = CW'(q.ptr) + CW'(1);
        last    = stat_in[TXB_WRAP] || (ptr_inc >= count);
        err     = done_stat[0] | done_stat[2] | done_stat[3] | done_stat[8];
        case (q.st)
            TX_IDLE: begin
                if (restart) begin
                    d.ptr = '0;
                end else if (en && (CW'(q.ptr) < count) && stat_in[TXB_READY]) begin
                    d.st   = TX_BUSY;
                    d.addr = addr_in;
                    d.len  = stat_in[31:16];
                    d.pad  = stat_in[TXB_PAD];
                    d.crc  = stat_in[TXB_CRC];
                end
            end
            default: begin
                if (restart) d.rst_pend = 1'b1;
                if (done) begin
                    wb_we = 1'b1;
                    if (stat_in[TXB_IRQ]) begin
                        set_txe = err;
                        set_txf = !err;
                    end
                    d.ptr      = (restart || q.rst_pend || last) ? '0 : ptr_inc[IW-1:0];
                    d.rst_pend = 1'b0;
                    d.st       = TX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, default: '0};
        else        q <= d;
    end

    assign ptr      = q.ptr;
    assign req      = (q.st == TX_BUSY);
    assign req_addr = q.addr;
    assign req_len  = q.len;
    assign req_pad  = q.pad;
    assign req_crc  = q.crc;
endmodule

// File: rtl/dring_rx.sv
module dring_rx
    import dring_pkg::*;
#(
    parameter int N        = 128,
    parameter int IW       = 7,
    parameter int CW       = 8,
    parameter int DEF_BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] base,
    input  logic          restart,
    input  logic [CW-1:0] new_base,
    input  logic [15:9]   stat_in,
    input  logic          frame,
    input  logic [15:0]   len,
    input  logic [8:0]    flags,
    output logic [IW-1:0] rd_idx,
    output logic          wb_we,
    output logic [31:0]   wb_data,
    output logic          set_rxf,
    output logic          set_rxe,
    output logic          set_rxc,
    output logic          set_drop
);
    typedef struct packed {
        logic [CW-1:0] ptr;
    } rx_reg_t;

    rx_reg_t q, d;
    logic [CW-1:0] nxt, adv;
    logic          avail;

    always_comb begin
        d        = q;
        set_rxf  = 1'b0;
        set_rxe  = 1'b0;
        set_rxc  = 1'b0;
        avail    = (q.ptr < CW'(N)) && stat_in[RXB_EMPTY];
        wb_we    = en && frame && avail;
        set_drop = en && frame && !avail;
        wb_data  = {len, 1'b0, stat_in[14:9], flags};
        nxt      = q.ptr + CW'(1);
        adv      = (stat_in[RXB_WRAP] || nxt >= CW'(N)) ? base : nxt;
        if (wb_we && stat_in[RXB_IRQ]) begin
            if (|flags[7:0])   set_rxe = 1'b1;
            else if (flags[8]) set_rxc = 1'b1;
            else               set_rxf = 1'b1;
        end
        if (restart)    d.ptr = new_base;
        else if (wb_we) d.ptr = adv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ptr: CW'(DEF_BASE)};
        else        q <= d;
    end

    assign rd_idx = IW'(q.ptr);
endmodule

// File: rtl/dring_qmgr.sv
module dring_qmgr
    import dring_pkg::*;
#(
    parameter int NUM_DESC  = 128,
    parameter int DEF_TXCNT = 64,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_req,
    output logic [31:0]       tx_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_stat,
    input  logic              rx_frame,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_flags,
    output logic              irq
);
    localparam int IW      = $clog2(NUM_DESC);
    localparam int CW      = $clog2(NUM_DESC + 1);
    localparam int TBL_END = OFS_TABLE + 8 * NUM_DESC;

    typedef struct packed {
        logic            rx_en;
        logic            tx_en;
        logic [NSRC-1:0] src;
        logic [NSRC-1:0] mask;
        logic [CW-1:0]   txcnt;
    } top_reg_t;

    top_reg_t q, d;

    logic            aligned, tbl_hit, tbl_we, restart;
    logic [IW-1:0]   tbl_idx, tx_ptr, rx_idx;
    logic [CW-1:0]   cnt_new;
    logic [NSRC-1:0] clr, int_set;
    logic [31:0]     tbl_rdata, tx_addr_in, tx_wb, rx_wb;
    logic [31:9]     tx_head;
    logic [15:9]     rx_head;
    logic            tx_wb_we, rx_wb_we;
    logic            s_txf, s_txe, s_rxf, s_rxe, s_rxc, s_drop;
    logic            rx_on, tx_on;
    logic [NSRC-1:0] int_src;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign tbl_hit = aligned && (reg_addr >= ADDR_W'(OFS_TABLE)) && (reg_addr < ADDR_W'(TBL_END));
    assign tbl_idx = IW'((reg_addr - ADDR_W'(OFS_TABLE)) >> 3);
    assign tbl_we  = reg_wr && tbl_hit;
    assign int_set = {s_rxc, 1'b0, s_drop, s_rxe, s_rxf, s_txe, s_txf};

    always_comb begin
        d       = q;
        restart = 1'b0;
        cnt_new = q.txcnt;
        clr     = '0;
        if (reg_wr && aligned && !tbl_hit) begin
            case (reg_addr)
                ADDR_W'(OFS_CTRL): begin
                    d.rx_en = reg_wdata[0];
                    d.tx_en = reg_wdata[1];
                end
                ADDR_W'(OFS_SRC):  clr    = reg_wdata[NSRC-1:0];
                ADDR_W'(OFS_MASK): d.mask = reg_wdata[NSRC-1:0];
                ADDR_W'(OFS_TXCNT): begin
                    cnt_new = (reg_wdata > 32'(NUM_DESC)) ? CW'(NUM_DESC) : CW'(reg_wdata);
                    d.txcnt = cnt_new;
                    restart = 1'b1;
                end
                default: ;
            endcase
        end
        // a new event outranks a clear of the same bit
        d.src = (q.src & ~clr) | int_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{txcnt: CW'(DEF_TXCNT), default: '0};
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (tbl_hit) begin
            reg_rdata = tbl_rdata;
        end else if (aligned) begin
            case (reg_addr)
                ADDR_W'(OFS_CTRL):  reg_rdata = {30'd0, q.tx_en, q.rx_en};
                ADDR_W'(OFS_SRC):   reg_rdata = 32'(q.src);
                ADDR_W'(OFS_MASK):  reg_rdata = 32'(q.mask);
                ADDR_W'(OFS_TXCNT): reg_rdata = 32'(q.txcnt);
                default:            reg_rdata = '0;
            endcase
        end
    end

    assign irq     = |(q.src & q.mask);
    assign rx_on   = q.rx_en;
    assign tx_on   = q.tx_en;
    assign int_src = q.src;

    dring_table #(.N(NUM_DESC), .IW(IW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .bus_we(tbl_we), .bus_idx(tbl_idx), .bus_hi(reg_addr[2]),
        .bus_wdata(reg_wdata), .bus_rdata(tbl_rdata),
        .tx_idx(tx_ptr), .tx_we(tx_wb_we), .tx_wdata(tx_wb),
        .tx_stat(tx_head), .tx_addr(tx_addr_in),
        .rx_idx(rx_idx), .rx_we(rx_wb_we), .rx_wdata(rx_wb),
        .rx_stat(rx_head)
    );

    dring_tx #(.IW(IW), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(q.tx_en), .count(q.txcnt),
        .restart(restart), .stat_in(tx_head), .addr_in(tx_addr_in),
        .done(tx_done), .done_stat(tx_stat), .ptr(tx_ptr),
        .req(tx_req), .req_addr(tx_addr), .req_len(tx_len),
        .req_pad(tx_pad), .req_crc(tx_crc),
        .wb_we(tx_wb_we), .wb_data(tx_wb),
        .set_txf(s_txf), .set_txe(s_txe)
    );

    dring_rx #(.N(NUM_DESC), .IW(IW), .CW(CW), .DEF_BASE(DEF_TXCNT)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(q.rx_en), .base(q.txcnt),
        .restart(restart), .new_base(cnt_new), .stat_in(rx_head),
        .frame(rx_frame), .len(rx_len), .flags(rx_flags),
        .rd_idx(rx_idx), .wb_we(rx_wb_we), .wb_data(rx_wb),
        .set_rxf(s_rxf), .set_rxe(s_rxe), .set_rxc(s_rxc), .set_drop(s_drop)
    );
endmodule

// File: rtl/dring_qmgr_chk.sv
module dring_qmgr_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              tx_req,
    input logic              tx_done,
    input logic              rx_frame,
    input logic              irq,
    input logic              rx_on,
    input logic              tx_on,
    input logic [15:9]       rx_head,
    input logic [6:0]        int_src,
    input logic [6:0]        int_set
);
    // R3: request is held until done
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> tx_req);

    // R4: request drops after done
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> !tx_req);

    // R11: a request only starts while transmit is enabled
    a_r11_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(tx_on));

    // R7: report onto a software-owned descriptor raises the drop bit
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame && rx_on && !rx_head[15]) |=> int_src[4]);

    // R9: an event bit survives any clear in its cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (int_set != 7'd0) |=> ((int_src & $past(int_set)) == $past(int_set)));

    // R9: full clear with no event empties the source register
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h004) && reg_wdata[6:0] == 7'h7f && int_set == 7'd0)
        |=> (int_src == 7'd0));

    // R10: zero mask silences the interrupt
    a_r10_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h008) && reg_wdata[6:0] == 7'd0) |=> !irq);
endmodule

bind dring_qmgr dring_qmgr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_req(tx_req), .tx_done(tx_done),
    .rx_frame(rx_frame), .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
    .rx_head(rx_head), .int_src(int_src), .int_set(int_set)
);

// File: tb/dring_qmgr_tb.sv
`timescale 1ns/100ps
module dring_qmgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req, tx_pad, tx_crc, irq;
    logic [31:0] tx_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_frame = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_flags = '0;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dring_qmgr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
        .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
        .tx_done(tx_done), .tx_stat(tx_stat), .rx_frame(rx_frame),
        .rx_len(rx_len), .rx_flags(rx_flags), .irq(irq)
    );

    function automatic logic [11:0] dst(int i); return 12'(32'h400 + 8 * i); endfunction
    function automatic logic [11:0] dad(int i); return 12'(32'h404 + 8 * i); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_req(output bit seen, input int lim);
        seen = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (tx_req) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic finish_tx(logic [8:0] s);
        tx_done = 1'b1; tx_stat = s;
        @(negedge clk);
        tx_done = 1'b0; tx_stat = '0;
    endtask

    task automatic frame(logic [15:0] l, logic [8:0] f);
        @(negedge clk);
        rx_frame = 1'b1; rx_len = l; rx_flags = f;
        @(negedge clk);
        rx_frame = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h004, v); check("R1 src", v, 0);
        rd(12'h020, v); check("R1 count", v, 64);
        rd(dst(0), v);  check("R1 desc", v, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 req", 32'(tx_req), 0);
    endtask

    task automatic t_tx_basic();
        logic [31:0] v; bit seen;
        wr(12'h008, 32'h7f);
        wr(12'h020, 4);
        rd(12'h020, v); check("R2 count", v, 4);
        wr(dad(0), 32'hA000_0000);
        wr(dst(0), 32'h0064_C800);
        wr(12'h000, 2);
        wait_req(seen, 10);
        check("R3 req", 32'(seen), 1);
        check("R3 addr", tx_addr, 32'hA000_0000);
        check("R3 len", 32'(tx_len), 100);
        check("R3 pad/crc", {30'd0, tx_pad, tx_crc}, 1);
        repeat (3) @(negedge clk);
        check("R3 held", 32'(tx_req), 1);
        finish_tx(9'h010);
        check("R4 req drop", 32'(tx_req), 0);
        rd(dst(0), v); check("R4 wb", v, 32'h0064_4810);
        rd(12'h004, v); check("R8 txf", v, 32'h01);
        check("R10 irq", 32'(irq), 1);
        repeat (10) @(negedge clk);
        check("R3 single", 32'(tx_req), 0);
        wr(12'h004, 32'h01);
        rd(12'h004, v); check("R9 clear", v, 0);
    endtask

    task automatic t_tx_wrap();
        logic [31:0] v; bit seen;
        wr(dad(1), 32'hB1); wr(dad(0), 32'hB0); wr(dad(2), 32'hB2);
        wr(dst(0), 32'h0040_8800);
        wr(dst(2), 32'h0020_8000);
        wr(dst(1), 32'h003C_F000);
        wait_req(seen, 10);
        check("R3 addr1", tx_addr, 32'hB1);
        check("R3 pad1", {30'd0, tx_pad, tx_crc}, 2);
        check("R3 len1", 32'(tx_len), 60);
        finish_tx(9'h100);
        rd(dst(1), v); check("R4 wb1", v, 32'h003C_7100);
        rd(12'h004, v); check("R8 txe", v, 32'h02);
        wait_req(seen, 10);
        check("R5 tx wrap", tx_addr, 32'hB0);
        finish_tx(9'h000);
        rd(12'h004, v); check("R8 no irq bit", v, 32'h02);
        rd(dst(0), v); check("R4 wb0", v, 32'h0040_0800);
        rd(dst(2), v); check("R5 skipped", v, 32'h0020_8000);
        wr(12'h004, 32'h7f);
    endtask

    task automatic t_tx_disable();
        logic [31:0] v; bit seen;
        wr(12'h000, 0);
        wr(dst(2), 0);
        wr(dad(1), 32'hD1);
        wr(dst(1), 32'h001E_C000);
        wait_req(seen, 20);
        check("R11 no req", 32'(seen), 0);
        rd(dst(1), v); check("R11 untouched", v, 32'h001E_C000);
        wr(12'h000, 2);
        wait_req(seen, 10);
        check("R11 resumes", tx_addr, 32'hD1);
        finish_tx(9'h000);
        wr(12'h000, 0);
        wr(12'h004, 32'h7f);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(dst(4), 32'h0000_C000);
        wr(dst(5), 32'h0000_E000);
        wr(dst(6), 32'h0000_C000);
        wr(12'h000, 1);
        frame(16'h05DC, 9'h000);
        rd(dst(4), v); check("R6 wb", v, 32'h05DC_4000);
        rd(12'h004, v); check("R8 rxf", v, 32'h04);
        wr(12'h004, 32'h7f);
        frame(16'd70, 9'h002);
        rd(dst(5), v); check("R6 wb err", v, 32'h0046_6002);
        rd(12'h004, v); check("R8 rxe", v, 32'h08);
        wr(12'h004, 32'h7f);
        wr(dst(4), 32'h0000_C000);
        frame(16'd64, 9'h100);
        rd(dst(4), v); check("R5 rx wrap", v, 32'h0040_4100);
        rd(dst(6), v); check("R5 rx skip", v, 32'h0000_C000);
        rd(12'h004, v); check("R8 rxc", v, 32'h40);
        wr(12'h004, 32'h7f);
    endtask

    task automatic t_rx_drop();
        logic [31:0] v;
        frame(16'd33, 9'h000);
        rd(12'h004, v); check("R7 drop bit", v, 32'h10);
        rd(dst(5), v); check("R7 no wb", v, 32'h0046_6002);
        wr(dst(5), 32'h0000_C000);
        frame(16'd80, 9'h000);
        rd(dst(5), v); check("R7 ptr held", v, 32'h0050_4000);
        wr(12'h004, 32'h7f);
        wr(12'h000, 0);
        frame(16'd90, 9'h000);
        rd(12'h004, v); check("R11 rx off src", v, 0);
        rd(dst(6), v); check("R11 rx off desc", v, 32'h0000_C000);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(12'h000, 1);
        frame(16'd40, 9'h000);
        rd(12'h004, v); check("R9 pre", v, 32'h04);
        wr(dst(7), 32'h0000_E000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h04;
        rx_frame = 1'b1; rx_len = 16'd41; rx_flags = '0;
        @(negedge clk);
        reg_wr = 1'b0; rx_frame = 1'b0;
        rd(12'h004, v); check("R9 set wins", v, 32'h04);
        rd(dst(7), v); check("R6 same cycle wb", v, 32'h0029_6000);
        wr(12'h008, 0);
        check("R10 masked", 32'(irq), 0);
        wr(12'h008, 32'h04);
        check("R10 unmasked", 32'(irq), 1);
        wr(12'h008, 32'h03);
        check("R10 other bits", 32'(irq), 0);
        wr(12'h004, 32'h04);
        rd(12'h004, v); check("R9 clear after", v, 0);
    endtask

    task automatic t_restart();
        logic [31:0] v; bit seen;
        wr(12'h000, 0);
        wr(12'h020, 2);
        wr(dst(2), 32'h0000_C000);
        wr(dad(0), 32'hC0);
        wr(dst(0), 32'h0010_8000);
        wr(12'h000, 3);
        frame(16'd50, 9'h000);
        rd(dst(2), v); check("R12 rx base", v, 32'h0032_4000);
        wait_req(seen, 10);
        check("R12 tx base", tx_addr, 32'hC0);
        finish_tx(9'h000);
        wr(12'h020, 32'hFF);
        rd(12'h020, v); check("R2 clamp", v, 128);
        wr(12'h004, 32'h7f);
        frame(16'd20, 9'h000);
        rd(12'h004, v); check("R7 empty ring", v, 32'h10);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_wrap();
        t_tx_disable();
        t_rx();
        t_rx_drop();
        t_same_cycle();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule